// File: doc/BRIEF.md
# Configurable serial shift engine

This block combines a serial transmitter and receiver in one shift register, in the manner of SPI. Software programs a control word, loads transmit data, then writes a bit count. Each capture edge of the serial clock takes one bit in from `sdi_i`, shifts one bit out, and lowers the count by one. When the count reaches zero, shifting stops and a completion flag is raised. The flag can drive an interrupt.

The shift register works on the low byte only or on the full 16-bit word, and shifts either MSB-first or LSB-first. In master mode the block makes the serial clock itself, toggling it on each `shift_tick_i` pulse while a transfer is pending. In slave mode it follows `sclk_i`. Clock polarity and phase are programmable. The serial output passes through a latch that either updates on change edges or is transparent.

All logic runs on `clk_i`. Slave-mode serial clock edges are found by comparing `sclk_i` with its value one clock earlier.

Top module: `ser_shift_engine`

## Requirements
- R1: After `rst_ni` falls, the control word reads 0x0001, so the block-reset bit is set. While the block-reset bit is 1, the count, the flag, the shift data and the serial output latch are forced to 0, and writes to the count and data registers have no effect.
- R2: Each shift lowers the count by one. Once the count is zero, further serial clock edges change neither the data nor the count. A count of N shifts exactly N bits.
- R3: The flag, read at count-register bit 6, becomes 1 when a shift brings the count from 1 to 0.
- R4: Writing the count register with a nonzero count and keep bit (bit 5) at 0 clears the flag. Writing with keep at 1, or with a zero count, leaves the flag as it was.
- R5: Width bit 0 shifts only data bits 7:0 and leaves bits 15:8 unchanged. Width bit 1 shifts all 16 bits.
- R6: When direction bit is 0 (MSB-first), the outgoing bit is bit 7 (or bit 15 in 16-bit mode) and the incoming bit enters at bit 0. When direction bit is 1 (LSB-first), the outgoing bit is bit 0 and the incoming bit enters at bit 7 (or bit 15).
- R7: With phase 0, the leading edge (leaving idle) is the change edge and the trailing edge is the capture edge. With phase 1, the roles are swapped. Shifts happen only on capture edges.
- R8: In master mode `sclk_o` idles at the polarity bit. In slave mode the logical clock level is `sclk_i` XOR polarity.
- R9: With transparent bit 0, `sdo_o` is a latch that loads the outgoing bit on each change edge and on each data write. With transparent bit 1, `sdo_o` follows the outgoing bit directly.
- R10: `sdo_oe_o` is 1 exactly when the output-enable bit is 1 and block reset is 0. `sclk_oe_o` is 1 exactly when master is 1 and block reset is 0.
- R11: In master mode, each `shift_tick_i` pulse toggles the serial clock while the count is nonzero or the clock is at its active level. Otherwise the serial clock stays idle.
- R12: `irq_o` is 1 exactly when both the flag and the interrupt-enable bit are 1.
- R13: Register map. Address 0 is control: bit0 block reset, bit1 output enable, bit2 transparent, bit3 master, bit4 LSB-first, bit5 phase, bit6 polarity, bit7 interrupt enable, bit8 16-bit width. Address 1 is count: bits 4:0 count, bit5 keep, bit6 flag (read only). Address 2 is the 16-bit data register. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| shift_tick_i | input | 1 | Bit-rate tick for master mode |
| sclk_i | input | 1 | Serial clock in (slave mode) |
| sclk_o | output | 1 | Serial clock out (master mode) |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| irq_o | output | 1 | Completion interrupt |

## Verification
Register reads are combinational, so they are compared in the cycle they are issued. A register write takes effect at the next rising edge of `clk_i`. In slave mode, a serial clock edge on `sclk_i` is acted on at the first rising edge of `clk_i` after the change. From that edge, the count, flag, data, `sdo_o` and `irq_o` all update within one clock. The bench therefore waits two clocks after each `sclk_i` change before sampling, and samples on the falling edge. In transparent mode, `sdo_o` is checked right after a capture edge and before the next change edge, which separates it from the latched behaviour. In master mode, serial clock edges are counted on falling edges while `shift_tick_i` is held high.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic wide;
    logic irq_en;
    logic pol;
    logic phase;
    logic lsb_first;
    logic master;
    logic transparent;
    logic oe;
    logic swrst;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RESET = '{swrst: 1'b1, default: 1'b0};
endpackage

// File: rtl/ser_regs.sv
module ser_regs
  import ser_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_ev_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              keep_o,
  output logic              flag_o
);
  logic ctrl_wr, cnt_wr;
  logic [CNT_W-1:0] cnt_new;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign cnt_wr  = we_i && (addr_i == ADDR_CNT);
  assign cnt_new = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RESET;
      cnt_o  <= '0;
      keep_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (cnt_wr) keep_o <= wdata_i[CNT_W];
      if (ctrl_o.swrst) begin
        cnt_o  <= '0;
        flag_o <= 1'b0;
      end else if (cnt_wr) begin
        // software load wins over a shift in the same cycle
        cnt_o <= cnt_new;
        if ((cnt_new != '0) && !wdata_i[CNT_W]) flag_o <= 1'b0;
      end else if (shift_ev_i && (cnt_o != '0)) begin
        cnt_o <= cnt_o - 1'b1;
        if (cnt_o == CNT_W'(1)) flag_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swrst_i,
  input  logic master_i,
  input  logic pol_i,
  input  logic phase_i,
  input  logic tick_i,
  input  logic cnt_nz_i,
  input  logic sclk_i,
  output logic sclk_o,
  output logic sclk_oe_o,
  output logic cap_ev_o,
  output logic chg_ev_o
);
  logic lvl_q, sclk_raw_q;
  logic m_ev, s_ev, ev, lead;

  // logical level: 0 = idle, 1 = active
  assign m_ev = master_i & ~swrst_i & tick_i & (cnt_nz_i | lvl_q);
  assign s_ev = ~master_i & ~swrst_i & (sclk_i ^ sclk_raw_q);
  assign ev   = master_i ? m_ev : s_ev;
  assign lead = master_i ? ~lvl_q : (sclk_i ^ pol_i);

  assign cap_ev_o = ev & (lead == phase_i);
  assign chg_ev_o = ev & (lead != phase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= 1'b0;
      sclk_raw_q <= 1'b0;
    end else begin
      sclk_raw_q <= sclk_i;
      if (swrst_i || !master_i) lvl_q <= 1'b0;
      else if (m_ev)            lvl_q <= ~lvl_q;
    end
  end

  assign sclk_o    = lvl_q ^ pol_i;
  assign sclk_oe_o = master_i & ~swrst_i;
endmodule

// File: rtl/ser_shreg.sv
module ser_shreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swrst_i,
  input  logic              wide_i,
  input  logic              lsb_first_i,
  input  logic              transparent_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_ev_i,
  input  logic              chg_ev_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sr_q, sr_nxt;
  logic latch_q, out_bit;

  function automatic logic pick_out(input logic [DATA_W-1:0] v, input logic wide,
                                    input logic lsb);
    if (lsb)       return v[0];
    else if (wide) return v[DATA_W-1];
    else           return v[HALF-1];
  endfunction

  assign out_bit = pick_out(sr_q, wide_i, lsb_first_i);

  always_comb begin
    sr_nxt = sr_q;
    if (lsb_first_i) begin
      if (wide_i) sr_nxt = {sdi_i, sr_q[DATA_W-1:1]};
      else        sr_nxt[HALF-1:0] = {sdi_i, sr_q[HALF-1:1]};
    end else begin
      if (wide_i) sr_nxt = {sr_q[DATA_W-2:0], sdi_i};
      else        sr_nxt[HALF-1:0] = {sr_q[HALF-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      latch_q <= 1'b0;
    end else if (swrst_i) begin
      sr_q    <= '0;
      latch_q <= 1'b0;
    end else if (data_we_i) begin
      sr_q    <= wdata_i;
      latch_q <= pick_out(wdata_i, wide_i, lsb_first_i);
    end else begin
      if (cap_ev_i) sr_q    <= sr_nxt;
      if (chg_ev_i) latch_q <= out_bit;
    end
  end

  assign data_o = sr_q;
  assign sdo_o  = transparent_i ? out_bit : latch_q;
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import ser_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              shift_tick_i,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] cnt_q;
  logic keep_q, flag_q, swrst, pol, cnt_nz;
  logic cap_ev, chg_ev, shift_ev;
  logic [DATA_W-1:0] data_q;

  assign swrst    = ctrl.swrst;
  assign pol      = ctrl.pol;
  assign cnt_nz   = (cnt_q != '0);
  assign shift_ev = cap_ev & cnt_nz;

  ser_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .shift_ev_i(shift_ev),
    .ctrl_o    (ctrl),
    .cnt_o     (cnt_q),
    .keep_o    (keep_q),
    .flag_o    (flag_q)
  );

  ser_clkgen i_clkgen (
    .clk_i, .rst_ni,
    .swrst_i  (swrst),
    .master_i (ctrl.master),
    .pol_i    (pol),
    .phase_i  (ctrl.phase),
    .tick_i   (shift_tick_i),
    .cnt_nz_i (cnt_nz),
    .sclk_i,
    .sclk_o,
    .sclk_oe_o,
    .cap_ev_o (cap_ev),
    .chg_ev_o (chg_ev)
  );

  ser_shreg #(.DATA_W(DATA_W)) i_shreg (
    .clk_i, .rst_ni,
    .swrst_i      (swrst),
    .wide_i       (ctrl.wide),
    .lsb_first_i  (ctrl.lsb_first),
    .transparent_i(ctrl.transparent),
    .data_we_i    (reg_we_i && (reg_addr_i == ADDR_DATA)),
    .wdata_i      (reg_wdata_i),
    .cap_ev_i     (shift_ev),
    .chg_ev_i     (chg_ev),
    .sdi_i,
    .data_o       (data_q),
    .sdo_o
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = DATA_W'(ctrl);
      ADDR_CNT:  reg_rdata_o = DATA_W'({flag_q, keep_q, cnt_q});
      ADDR_DATA: reg_rdata_o = data_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign sdo_oe_o = ctrl.oe & ~swrst;
  assign irq_o    = flag_q & ctrl.irq_en;
endmodule

// File: rtl/ser_shift_chk.sv
module ser_shift_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              sclk_o,
  input logic              sclk_oe_o,
  input logic              sdo_oe_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              flag_q,
  input logic              keep_q,
  input logic              swrst,
  input logic              pol,
  input logic              shift_ev
);
  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = reg_we_i && (reg_addr_i == 2'd1);
  assign ctrl_wr = reg_we_i && (reg_addr_i == 2'd0);

  // R1
  swrst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (cnt_q == '0) && !flag_q);

  // R2
  cnt_zero_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !cnt_wr |=> cnt_q == '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && !cnt_wr && !swrst |=>
      (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));

  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1)) && shift_ev && !cnt_wr && !swrst |=> flag_q);

  // R4
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr && (reg_wdata_i[CNT_W-1:0] != '0) && !reg_wdata_i[CNT_W] |=> !flag_q);

  // R10
  oe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o || sclk_oe_o) |-> !swrst);

  // R11
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_oe_o && (cnt_q == '0) && (sclk_o == pol) && !ctrl_wr |=> sclk_o == $past(pol));

  // R12
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !keep_q |-> cnt_q == '0);
endmodule

bind ser_shift_engine ser_shift_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_ser_shift_engine.sv
`timescale 1ns/1ps
module test_ser_shift_engine;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, tick = 1'b0, sclk_in = 1'b0, sdi_drv = 1'b0, loop = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic sclk_o, sclk_oe, sdo, sdo_oe, irq, sdi_w;
  logic rd_req = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sdi_w = loop ? sdo : sdi_drv;

  ser_shift_engine i_ser_shift_engine (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .shift_tick_i(tick),
    .sclk_i(sclk_in), .sclk_o, .sclk_oe_o(sclk_oe), .sdi_i(sdi_w),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_o(irq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for register reads
  always @(negedge clk) if (rd_req) begin
    logic [15:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, reg_rdata, e);
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1 reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string t);
    @(posedge clk); #1 reg_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 rd_req = 1'b0;
  endtask

  task automatic sck(logic v);
    @(posedge clk); #1 sclk_in = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pin(string t, logic act, logic exp);
    @(negedge clk); chk(t, 16'(act), 16'(exp));
  endtask

  initial begin
    logic [15:0] pat;
    int rises;
    logic prev;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 R13 reset state
    rd(2'd0, 16'h0001, "R1 ctrl reset");
    rd(2'd1, 16'h0000, "R1 cnt reset");
    rd(2'd3, 16'h0000, "R13 unused addr");
    pin("R10 sdo_oe reset", sdo_oe, 1'b0);
    pin("R10 sclk_oe reset", sclk_oe, 1'b0);
    pin("R12 irq reset", irq, 1'b0);
    // R1 writes ignored under block reset
    wr(2'd2, 16'hBEEF);
    wr(2'd1, 16'h0008);
    rd(2'd2, 16'h0000, "R1 data held");
    rd(2'd1, 16'h0000, "R1 cnt held");

    // slave, phase 0, pol 0, MSB, 8-bit, latched, irq_en
    wr(2'd0, 16'h0082);
    pin("R10 sdo_oe on", sdo_oe, 1'b1);
    pin("R10 sclk_oe slave", sclk_oe, 1'b0);
    wr(2'd2, 16'h12A5);
    pin("R9 latch on write", sdo, 1'b1);
    wr(2'd1, 16'h0008);
    pat = 16'h003C;
    for (int k = 0; k < 8; k++) begin
      sdi_drv = pat[7-k];
      sck(1'b1);
      chk("R7 R6 sdo after change edge", 16'(sdo), 16'(8'hA5 >> (7-k) & 1));
      sck(1'b0);
    end
    rd(2'd2, 16'h123C, "R5 R6 rx msb 8-bit");
    rd(2'd1, 16'h0040, "R3 flag at zero");
    pin("R12 irq set", irq, 1'b1);
    sdi_drv = 1'b1;
    sck(1'b1); sck(1'b0);
    rd(2'd2, 16'h123C, "R2 no shift at zero");

    // R4 flag clear control
    wr(2'd1, 16'h0023);
    rd(2'd1, 16'h0063, "R4 keep holds flag");
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0040, "R4 zero count keeps flag");
    wr(2'd1, 16'h0003);
    rd(2'd1, 16'h0003, "R4 reload clears flag");
    pin("R12 irq cleared", irq, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sdi_drv = (k != 1);
      sck(1'b1); sck(1'b0);
    end
    rd(2'd2, 16'h12E5, "R2 partial count 3");
    rd(2'd1, 16'h0040, "R2 R3 count 3 done");

    // slave 16-bit LSB-first, phase 1, pol 1
    wr(2'd0, 16'h01F2);
    sck(1'b1);
    wr(2'd2, 16'h8001);
    pin("R9 latch lsb write", sdo, 1'b1);
    wr(2'd1, 16'h0010);
    pat = 16'hC3A5;
    for (int k = 0; k < 16; k++) begin
      sdi_drv = pat[k];
      sck(1'b0);
      if (k == 0) chk("R9 latch holds past capture", 16'(sdo), 16'h1);
      sck(1'b1);
      if (k < 15) chk("R7 R8 sdo phase1 pol1", 16'(sdo), 16'(16'h8001 >> (k+1) & 1));
    end
    rd(2'd2, 16'hC3A5, "R5 R6 rx lsb 16-bit");
    rd(2'd1, 16'h0040, "R3 flag 16-bit");

    // R9 transparent
    wr(2'd0, 16'h01F6);
    wr(2'd2, 16'h0002);
    wr(2'd1, 16'h0001);
    pin("R9 transparent follows", sdo, 1'b0);
    sdi_drv = 1'b1;
    sck(1'b0);
    chk("R9 transparent after capture", 16'(sdo), 16'h1);
    sck(1'b1);
    rd(2'd2, 16'h8001, "R6 lsb shift-in top");

    // master loopback, pol 0, phase 0, MSB 8-bit
    sck(1'b0);
    wr(2'd0, 16'h008A);
    pin("R10 sclk_oe master", sclk_oe, 1'b1);
    pin("R8 sclk idle low", sclk_o, 1'b0);
    loop = 1'b1;
    wr(2'd2, 16'h0096);
    wr(2'd1, 16'h0008);
    rises = 0; prev = sclk_o;
    @(posedge clk); #1 tick = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sclk_o && !prev) rises++;
      prev = sclk_o;
    end
    @(posedge clk); #1 tick = 1'b0;
    loop = 1'b0;
    chk("R11 master sclk pulses", 16'(rises), 16'd8);
    pin("R11 sclk back idle", sclk_o, 1'b0);
    rd(2'd2, 16'h0096, "R11 loopback rotate");
    pin("R12 irq master", irq, 1'b1);
    wr(2'd0, 16'h00CA);
    pin("R8 sclk idle high", sclk_o, 1'b1);
    @(posedge clk); #1 tick = 1'b1;
    repeat (6) @(posedge clk);
    #1 tick = 1'b0;
    pin("R11 no toggle at zero", sclk_o, 1'b1);

    // R1 block reset again
    wr(2'd0, 16'h0001);
    pin("R10 oe off in reset", sdo_oe, 1'b0);
    pin("R10 sclk_oe off in reset", sclk_oe, 1'b0);
    rd(2'd1, 16'h0000, "R1 flag cleared");
    rd(2'd2, 16'h0000, "R1 data cleared");
    pin("R12 irq off", irq, 1'b0);

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule